// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Sequencer

This block is the digital control core of a 16-bit successive-approximation converter with a three-wire serial port. The data clock comes from outside and paces every step of the block. A low-active select line starts a conversion. The same line, when high, shuts the block down. After select falls, the block spends a fixed number of clock periods sampling. It then decides the result one bit at a time. It does this by presenting a trial word to the external DAC array and reading back a single comparator bit.

Each decided bit goes onto the serial line in the period in which it is decided, so the output has no pipeline delay. The stream has four parts:
- a LOW null bit,
- the result with the most significant bit first,
- the result again with the least significant bit first, without repeating bit 0,
- then the line returns to high impedance.

Every state change happens on the falling edge of the data clock, so a receiver can capture each bit on the rising edge. Two flags report power state. The analog flag is high while the analog section is needed. The digital flag is high while the port is selected.

Top module: `adc_sar_seq`

## Requirements
- R1: After `cs_n` falls, the first 5 falling edges of `sclk` form the sampling window. During this window `sdo_oe` stays low.
- R2: Right after the 5th falling edge, `sdo_oe` goes high and `sdo` is 0 for one period (the null bit). At the same time `dac_word` holds 16'h8000.
- R3: On falling edges 6 through 21, `sdo` carries result bits 15 down to 0. Each bit is the comparator decision taken at that same edge.
- R4: Each trial sets the next lower bit of `dac_word`. At a decision edge, the bit under trial is kept if `cmp_ge` is 1 (input at or above the trial level) and cleared otherwise. From edge 21 on, `dac_word` equals the result.
- R5: On falling edges 22 through 36, `sdo` carries result bits 1 up to 15. Bit 0 is not sent a second time.
- R6: From the 37th falling edge on, `sdo_oe` is low. While `cs_n` stays low, further clocks change no output.
- R7: While `cs_n` is high, `sdo_oe`, `ana_active` and `dig_active` are low with no clock edge needed, and any conversion in progress is abandoned. A new conversion needs `cs_n` to be high across at least one falling edge and then low again.
- R8: `ana_active` is high from the fall of `cs_n` until bit 0 has been decided at edge 21, and low after that. `dig_active` is high exactly when `cs_n` is low.
- R9: The result is straight binary and equals the sampled code. A code of 0 gives 16'h0000, mid-scale gives 16'h8000 and full scale gives 16'hFFFF. The bench models the comparator as `cmp_ge = (dac_word <= code)`.
- R10: A low `rst_n` clears the sequencer at once, with no clock edge needed. `sdo` is 0 whenever `sdo_oe` is low.
- R11: `sdo` changes only at falling edges of `sclk`. It holds its value across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | External data clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released on a falling edge |
| cs_n | input | 1 | Select, active low; high means shutdown and abort |
| cmp_ge | input | 1 | Comparator: 1 when the sampled input is at or above `dac_word` |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for the serial pad; low means high impedance |
| dac_word | output | 16 | Trial word driven to the capacitor DAC |
| ana_active | output | 1 | Analog section must be powered |
| dig_active | output | 1 | Digital section must be powered |

## Verification
All observable behaviour hangs on one edge counter and one decided-bit register.

A wrong count moves the null bit, the enable window or the fall of `ana_active` by one falling edge. The bench sees this within the same period, because it compares every period of every conversion against a timeline built from the edge number.

A wrong decided bit shows up in two places. It appears on `dac_word` at the next edge. It appears again on the serial line, in the MSB-first word and later in the LSB-first repeat.

An abort that leaves state behind shows up in the first conversion after it, because the bench reruns a full conversion with a different code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_SAMPLE,
    PH_NULL,
    PH_MSB,
    PH_LSB,
    PH_DONE
  } phase_e;

  // Decode the phase that holds after edge number c of a conversion.
  function automatic phase_e phase_of(input int unsigned c,
                                      input int unsigned sc,
                                      input int unsigned res);
    if (c < sc)                 return PH_SAMPLE;
    else if (c == sc)           return PH_NULL;
    else if (c <= sc + res)     return PH_MSB;
    else if (c < sc + 2 * res)  return PH_LSB;
    else                        return PH_DONE;
  endfunction

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic sclk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/adc_seq_count.sv
module adc_seq_count #(
  parameter int RES         = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int CNT_W       = 6
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  output logic [CNT_W-1:0] cnt,
  output logic             advance
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_CLKS + 2 * RES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    advance = !cs_n && (cnt_q != LAST);
    cnt_en  = cs_n || advance;
    cnt_d   = cnt_q;
    if (cs_n)         cnt_d = '0;
    else if (advance) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES         = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int CNT_W       = 6
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             advance,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_ge,
  output logic [RES-1:0]   res,
  output logic [RES-1:0]   trial
);
  localparam logic [CNT_W-1:0] LOAD_AT  = CNT_W'(SAMPLE_CLKS - 1);
  localparam logic [CNT_W-1:0] DEC_LO   = CNT_W'(SAMPLE_CLKS);
  localparam logic [CNT_W-1:0] DEC_HI   = CNT_W'(SAMPLE_CLKS + RES);
  localparam logic [RES-1:0]   TOP_BIT  = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] res_q, res_d, trial_q, trial_d;
  logic           load, decide, sar_en;

  always_comb begin
    load    = advance && (cnt == LOAD_AT);
    decide  = advance && (cnt >= DEC_LO) && (cnt < DEC_HI);
    sar_en  = cs_n || load || decide;
    res_d   = res_q;
    trial_d = trial_q;
    if (cs_n) begin
      res_d   = '0;
      trial_d = '0;
    end else if (load) begin
      res_d   = '0;
      trial_d = TOP_BIT;
    end else if (decide) begin
      res_d   = res_q | (cmp_ge ? trial_q : '0);
      trial_d = trial_q >> 1;
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      trial_q <= '0;
    end else if (sar_en) begin
      res_q   <= res_d;
      trial_q <= trial_d;
    end
  end

  assign res   = res_q;
  assign trial = trial_q;
endmodule

// File: rtl/adc_out_ser.sv
module adc_out_ser
  import adc_seq_pkg::*;
#(
  parameter int RES         = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int CNT_W       = 6
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             advance,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_ge,
  input  logic [RES-1:0]   res,
  output logic             bit_out
);
  logic [CNT_W-1:0] cnt_nx;
  logic [RES-1:0]   rep_sel;
  phase_e           ph_nx;
  logic             bit_q, bit_d, rep_bit, out_en;

  assign cnt_nx = cnt + CNT_W'(1);

  // One select line per result bit for the LSB-first repeat.
  for (genvar b = 0; b < RES; b++) begin : g_rep
    assign rep_sel[b] = (cnt_nx == CNT_W'(SAMPLE_CLKS + RES + b));
  end

  always_comb begin
    ph_nx   = phase_of(int'(cnt_nx), SAMPLE_CLKS, RES);
    rep_bit = |(rep_sel & res);
    out_en  = cs_n || advance;
    bit_d   = 1'b0;
    if (!cs_n) begin
      unique case (ph_nx)
        PH_MSB:  bit_d = cmp_ge;
        PH_LSB:  bit_d = rep_bit;
        default: bit_d = 1'b0;
      endcase
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)      bit_q <= 1'b0;
    else if (out_en) bit_q <= bit_d;
  end

  assign bit_out = bit_q;
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int RES         = 16,
  parameter int SAMPLE_CLKS = 5
) (
  input  logic           sclk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           cmp_ge,
  output logic           sdo,
  output logic           sdo_oe,
  output logic [RES-1:0] dac_word,
  output logic           ana_active,
  output logic           dig_active
);
  localparam int               LAST_EDGE = SAMPLE_CLKS + 2 * RES;
  localparam int               CNT_W     = $clog2(LAST_EDGE + 1);
  localparam logic [CNT_W-1:0] ANA_END   = CNT_W'(SAMPLE_CLKS + RES);

  logic             rst_sync_n, advance, bit_out;
  logic [CNT_W-1:0] cnt;
  logic [RES-1:0]   res, trial;
  phase_e           ph;

  adc_rst_sync u_rst (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_seq_count #(.RES(RES), .SAMPLE_CLKS(SAMPLE_CLKS), .CNT_W(CNT_W)) u_cnt (
    .sclk    (sclk),
    .rst_n   (rst_sync_n),
    .cs_n    (cs_n),
    .cnt     (cnt),
    .advance (advance)
  );

  adc_sar_core #(.RES(RES), .SAMPLE_CLKS(SAMPLE_CLKS), .CNT_W(CNT_W)) u_sar (
    .sclk    (sclk),
    .rst_n   (rst_sync_n),
    .cs_n    (cs_n),
    .advance (advance),
    .cnt     (cnt),
    .cmp_ge  (cmp_ge),
    .res     (res),
    .trial   (trial)
  );

  adc_out_ser #(.RES(RES), .SAMPLE_CLKS(SAMPLE_CLKS), .CNT_W(CNT_W)) u_ser (
    .sclk    (sclk),
    .rst_n   (rst_sync_n),
    .cs_n    (cs_n),
    .advance (advance),
    .cnt     (cnt),
    .cmp_ge  (cmp_ge),
    .res     (res),
    .bit_out (bit_out)
  );

  always_comb begin
    ph         = phase_of(int'(cnt), SAMPLE_CLKS, RES);
    sdo_oe     = !cs_n && (ph inside {PH_NULL, PH_MSB, PH_LSB});
    sdo        = sdo_oe && bit_out;
    ana_active = !cs_n && (cnt < ANA_END);
    dig_active = !cs_n;
    dac_word   = res | trial;
  end
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int RES = 16
) (
  input logic           sclk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           sdo,
  input logic           sdo_oe,
  input logic [RES-1:0] dac_word,
  input logic           ana_active,
  input logic           dig_active
);
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  // R7
  shutdown_quiet_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    cs_n |-> (!sdo_oe && !ana_active && !dig_active));

  // R10
  idle_line_low_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R2
  null_bit_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (!sdo && dac_word == TOP_BIT));

  // R8
  ana_off_while_driving_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    ($fell(ana_active) && !cs_n) |-> sdo_oe);

  // R6
  done_hold_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !ana_active && !sdo_oe && $past(!sdo_oe))
      |-> $stable(dac_word));
endmodule

bind adc_sar_seq adc_sar_seq_chk #(.RES(RES)) chk_i (
  .sclk       (sclk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .dac_word   (dac_word),
  .ana_active (ana_active),
  .dig_active (dig_active)
);

// File: tb/adc_sar_seq_tb_top.sv
module adc_sar_seq_tb_top;
  localparam int P    = 20;
  localparam int SC   = 5;
  localparam int RES  = 16;
  localparam int LAST = SC + 2 * RES;
  localparam int NVEC = 8;
  // {sample code, expected result}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000}, {16'h8000, 16'h8000}, {16'hFFFF, 16'hFFFF},
    {16'h7FFF, 16'h7FFF}, {16'h0001, 16'h0001}, {16'hA5C3, 16'hA5C3},
    {16'h5A3C, 16'h5A3C}, {16'h8001, 16'h8001}
  };

  logic        sclk, rst_n, cs_n, cmp_ge;
  logic        sdo, sdo_oe, ana_active, dig_active;
  logic [15:0] dac_word, sample_code;
  int          n_chk, n_fail;
  bit          finished;

  adc_sar_seq dut_i (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cmp_ge(cmp_ge),
    .sdo(sdo), .sdo_oe(sdo_oe), .dac_word(dac_word),
    .ana_active(ana_active), .dig_active(dig_active)
  );

  assign cmp_ge = (dac_word <= sample_code);

  initial sclk = 1'b1;
  always #(P/2) sclk = ~sclk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge sclk);
    #(P/4);
  endtask

  task automatic run_conv(input logic [15:0] code, input logic [15:0] exp);
    logic [15:0] msb_w, lsb_w, exp_dac;
    logic        e_oe, e_sdo, e_ana, s_early;
    msb_w = '0;
    lsb_w = '0;
    sample_code = code;
    cs_n = 1'b0;
    #1;
    chk("R1 oe before first edge", {31'b0, sdo_oe}, 32'd0);
    chk("R8 ana at select", {31'b0, ana_active}, 32'd1);
    chk("R8 dig at select", {31'b0, dig_active}, 32'd1);
    for (int k = 1; k <= LAST + 4; k++) begin
      tick();
      e_oe  = (k >= SC) && (k < LAST);
      e_ana = (k < SC + RES);
      e_sdo = 1'b0;
      if (k > SC && k <= SC + RES)        e_sdo = exp[SC + RES - k];
      else if (k > SC + RES && k < LAST)  e_sdo = exp[k - SC - RES];
      if (k < SC) exp_dac = 16'h0000;
      else if (k < SC + RES) begin
        int i;
        i = SC + RES - 1 - k;
        exp_dac = 16'((32'(exp) & (32'hFFFF << (i + 1))) | (32'd1 << i));
      end else exp_dac = exp;
      if (k < SC)
        chk("R1 oe in sampling window", {31'b0, sdo_oe}, 32'd0);
      else if (k == SC)
        chk("R2 null bit", {30'b0, sdo_oe, sdo}, 32'd2);
      else if (k <= SC + RES)
        chk("R3 msb-first bit", {30'b0, sdo_oe, sdo}, {30'b0, e_oe, e_sdo});
      else if (k < LAST)
        chk("R5 lsb-first repeat bit", {30'b0, sdo_oe, sdo}, {30'b0, e_oe, e_sdo});
      else
        chk("R6 tri-state after repeat", {30'b0, sdo_oe, sdo}, 32'd0);
      chk("R8 ana_active", {31'b0, ana_active}, {31'b0, e_ana});
      chk(k >= LAST ? "R6 dac held" : "R4 dac trial word", {16'b0, dac_word}, {16'b0, exp_dac});
      if (k > SC && k <= SC + RES) msb_w[SC + RES - k] = sdo;
      if (k > SC + RES && k < LAST) lsb_w[k - SC - RES] = sdo;
      s_early = sdo;
      #(P/2);
      chk("R11 sdo stable over rising edge", {31'b0, sdo}, {31'b0, s_early});
    end
    chk("R9 msb-first word", {16'b0, msb_w}, {16'b0, exp});
    chk("R5 lsb-first word bits 15..1", {16'b0, lsb_w[15:1]}, {16'b0, exp[15:1]});
    chk("R5 b0 not repeated", {31'b0, lsb_w[0]}, 32'd0);
    cs_n = 1'b1;
    #1;
    chk("R7 deselect quiet", {29'b0, sdo_oe, ana_active, dig_active}, 32'd0);
    tick();
    tick();
  endtask

  initial begin : watchdog
    #(P * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    n_chk = 0;
    n_fail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    cs_n = 1'b1;
    sample_code = '0;
    #(P/4);
    chk("R10 reset oe", {30'b0, sdo_oe, sdo}, 32'd0);
    chk("R7 reset flags", {30'b0, ana_active, dig_active}, 32'd0);
    chk("R10 reset dac", {16'b0, dac_word}, 32'd0);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    for (int v = 0; v < NVEC; v++)
      run_conv(VEC[v][31:16], VEC[v][15:0]);

    // R7: abort mid-conversion, then a clean restart
    sample_code = 16'hFFFF;
    cs_n = 1'b0;
    repeat (12) tick();
    chk("R7 driving before abort", {31'b0, sdo_oe}, 32'd1);
    cs_n = 1'b1;
    #1;
    chk("R7 abort quiet", {29'b0, sdo_oe, ana_active, dig_active}, 32'd0);
    tick();
    tick();
    run_conv(16'h1234, 16'h1234);

    // R10: asynchronous reset in the middle of a conversion
    sample_code = 16'h0F0F;
    cs_n = 1'b0;
    repeat (8) tick();
    rst_n = 1'b0;
    #1;
    chk("R10 reset drops oe", {30'b0, sdo_oe, sdo}, 32'd0);
    chk("R10 reset clears dac", {16'b0, dac_word}, 32'd0);
    chk("R8 ana after reset with select low", {31'b0, ana_active}, 32'd1);
    cs_n = 1'b1;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    run_conv(16'hC0DE, 16'hC0DE);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule